// File: doc/BRIEF.md
# Frequency Select and Watchdog Recovery Controller

This controller decides which divider pair (N, M) and which frequency-ratio code a clock synthesizer should use. There are three possible sources. The hardware selection is a divider pair supplied by the strap decode. The programmed pair comes from software registers. The recovery pair is applied after a watchdog expiry. The ratio code comes either from a strap value captured when power-good rises or from a software select field.

Programmed values do not take effect when their registers change. They are applied only when the serial interface writes the M field. Each such write, and each watchdog expiry, produces a one-cycle load strobe and a fixed-length active-low reset pulse. After an expiry, the chosen recovery settings stay in force until software writes M again. The PLL and the clock dividers are not part of this block.

Top module: `freqsel_wdog_ctrl`

## Requirements
- R1: After reset, the active source is the hardware selection (`outN`=`hwN`, `outM`=`hwM`), the captured strap value is 0, `loadStb` is 0 and `rstOutN` is 1.
- R2: `fsStrap` is captured on the first rising clock edge at which `pwrGood` is sampled high after having been low. The captured value is visible from the next cycle. Later changes of `fsStrap` have no effect until `pwrGood` falls and rises again.
- R3: `outRatio` is combinational. With `overrideEn`=0 it equals the captured strap value. With `overrideEn`=1 it equals `selReg`.
- R4: A cycle with `mWriteStb`=1 and `progEn`=1 makes `outN`/`outM` equal to `progN`/`progM` as sampled in that cycle, from the next cycle on. A write with `progEn`=0 selects the live hardware pair instead.
- R5: Changing `progEn`, `progN` or `progM` without an M write does not change `outN`/`outM`. While the hardware source is active, `outN`/`outM` follow `hwN`/`hwM` directly.
- R6: With a nonzero `wdPeriod` P, a timeout occurs at the P-th rising edge after the last edge that counted a kick, or after the last timeout. `wdKick` held high prevents timeouts. `wdPeriod`=0 disables the watchdog and clears its count.
- R7: On a timeout with `recSel`=1, `recN`/`recM` as sampled in that cycle become the active pair. On a timeout with `recSel`=0, the hardware pair becomes active.
- R8: After a timeout, the recovery pair stays active regardless of later `recN`/`recM` changes, and remains so until the next M write.
- R9: `rstOutN` goes low in the cycle after a timeout or an M write and stays low for exactly 16 cycles. A new event during the pulse restarts the 16-cycle count.
- R10: If a timeout and an M write fall in the same cycle, the timeout decides the new source.
- R11: `loadStb` is high for one cycle after each timeout or M write, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| pwrGood | input | 1 | Power-good; strap capture on its rise |
| fsStrap | input | 5 | Strap ratio code |
| hwN | input | 8 | Hardware-selected N |
| hwM | input | 7 | Hardware-selected M |
| progEn | input | 1 | Programmable-frequency enable |
| progN | input | 8 | Programmed N |
| progM | input | 7 | Programmed M |
| mWriteStb | input | 1 | One-cycle strobe: M field written |
| overrideEn | input | 1 | Ratio code from software when 1 |
| selReg | input | 5 | Software ratio code |
| recSel | input | 1 | Use recovery pair on timeout |
| recN | input | 8 | Recovery N |
| recM | input | 7 | Recovery M |
| wdPeriod | input | 16 | Watchdog period in cycles, 0 = off |
| wdKick | input | 1 | Watchdog restart |
| outN | output | 8 | Active N |
| outM | output | 7 | Active M |
| outRatio | output | 5 | Active ratio code |
| loadStb | output | 1 | One-cycle load pulse |
| rstOutN | output | 1 | Active-low reset pulse |

## Verification
Source changes, `loadStb` and the fall of `rstOutN` all come one register stage after the edge that sees the write or the timeout. The bench therefore drives each stimulus on a falling edge and checks at the next falling edge. `outRatio` is combinational and is checked at the falling edge after its inputs change. Timeouts are counted from the edge that takes the kick. The bench confirms the result is still absent one edge early and present exactly at edge P. For the reset pulse, the bench counts 16 low samples and then one high sample.

// File: rtl/freqsel_pkg.sv
package freqsel_pkg;
  typedef enum logic [1:0] {SRC_HW, SRC_PROG, SRC_RECOV} srcSel_e;

  typedef struct packed {
    logic capProg;
    logic capRecov;
    logic useHw;
  } ctrlStb_t;
endpackage

// File: rtl/freqsel_ctrl.sv
module freqsel_ctrl
  import freqsel_pkg::*;
#(
  parameter int WD_W    = 16,
  parameter int RST_LEN = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            mWriteStb,
  input  logic            progEn,
  input  logic            recSel,
  input  logic [WD_W-1:0] wdPeriod,
  input  logic            wdKick,
  output ctrlStb_t        strobes,
  output logic            wdTimeout,
  output logic            loadStb,
  output logic            rstOutN
);
  localparam int RST_CW = $clog2(RST_LEN + 1);

  logic [WD_W-1:0]   wdCnt;
  logic [RST_CW-1:0] rstCnt;
  logic              wdOn;
  logic              anyEvent;

  assign wdOn      = (wdPeriod != '0);
  assign wdTimeout = wdOn && !wdKick && (wdCnt == wdPeriod - WD_W'(1));
  assign anyEvent  = wdTimeout || mWriteStb;

  // timeout has priority over a coincident M write (R10)
  always_comb begin
    strobes          = '0;
    strobes.capRecov = wdTimeout && recSel;
    strobes.useHw    = (wdTimeout && !recSel) || (!wdTimeout && mWriteStb && !progEn);
    strobes.capProg  = !wdTimeout && mWriteStb && progEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (!wdOn || wdKick || wdTimeout) begin
      wdCnt <= '0;
    end else begin
      wdCnt <= wdCnt + WD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt  <= '0;
      loadStb <= 1'b0;
    end else begin
      loadStb <= anyEvent;
      if (anyEvent) begin
        rstCnt <= RST_CW'(RST_LEN);
      end else if (rstCnt != '0) begin
        rstCnt <= rstCnt - RST_CW'(1);
      end
    end
  end

  assign rstOutN = (rstCnt == '0);
endmodule

// File: rtl/freqsel_datapath.sv
module freqsel_datapath
  import freqsel_pkg::*;
#(
  parameter int N_W  = 8,
  parameter int M_W  = 7,
  parameter int FS_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwrGood,
  input  logic [FS_W-1:0] fsStrap,
  input  logic [N_W-1:0]  hwN,
  input  logic [M_W-1:0]  hwM,
  input  logic [N_W-1:0]  progN,
  input  logic [M_W-1:0]  progM,
  input  logic [N_W-1:0]  recN,
  input  logic [M_W-1:0]  recM,
  input  logic            overrideEn,
  input  logic [FS_W-1:0] selReg,
  input  ctrlStb_t        strobes,
  output logic [N_W-1:0]  outN,
  output logic [M_W-1:0]  outM,
  output logic [FS_W-1:0] outRatio
);
  logic            pwrGoodQ;
  logic [FS_W-1:0] fsLatched;
  srcSel_e         srcSel;
  logic [N_W-1:0]  capN;
  logic [M_W-1:0]  capM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrGoodQ  <= 1'b0;
      fsLatched <= '0;
    end else begin
      pwrGoodQ <= pwrGood;
      if (pwrGood && !pwrGoodQ) fsLatched <= fsStrap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel <= SRC_HW;
      capN   <= '0;
      capM   <= '0;
    end else if (strobes.capRecov) begin
      srcSel <= SRC_RECOV;
      capN   <= recN;
      capM   <= recM;
    end else if (strobes.capProg) begin
      srcSel <= SRC_PROG;
      capN   <= progN;
      capM   <= progM;
    end else if (strobes.useHw) begin
      srcSel <= SRC_HW;
    end
  end

  always_comb begin
    if (srcSel == SRC_HW) begin
      outN = hwN;
      outM = hwM;
    end else begin
      outN = capN;
      outM = capM;
    end
    outRatio = overrideEn ? selReg : fsLatched;
  end
endmodule

// File: rtl/freqsel_wdog_ctrl.sv
module freqsel_wdog_ctrl
  import freqsel_pkg::*;
#(
  parameter int N_W     = 8,
  parameter int M_W     = 7,
  parameter int FS_W    = 5,
  parameter int WD_W    = 16,
  parameter int RST_LEN = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwrGood,
  input  logic [FS_W-1:0] fsStrap,
  input  logic [N_W-1:0]  hwN,
  input  logic [M_W-1:0]  hwM,
  input  logic            progEn,
  input  logic [N_W-1:0]  progN,
  input  logic [M_W-1:0]  progM,
  input  logic            mWriteStb,
  input  logic            overrideEn,
  input  logic [FS_W-1:0] selReg,
  input  logic            recSel,
  input  logic [N_W-1:0]  recN,
  input  logic [M_W-1:0]  recM,
  input  logic [WD_W-1:0] wdPeriod,
  input  logic            wdKick,
  output logic [N_W-1:0]  outN,
  output logic [M_W-1:0]  outM,
  output logic [FS_W-1:0] outRatio,
  output logic            loadStb,
  output logic            rstOutN
);
  ctrlStb_t strobes;
  logic     wdTimeout;

  freqsel_ctrl #(.WD_W(WD_W), .RST_LEN(RST_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .mWriteStb(mWriteStb), .progEn(progEn),
    .recSel(recSel), .wdPeriod(wdPeriod), .wdKick(wdKick),
    .strobes(strobes), .wdTimeout(wdTimeout), .loadStb(loadStb),
    .rstOutN(rstOutN)
  );

  freqsel_datapath #(.N_W(N_W), .M_W(M_W), .FS_W(FS_W)) u_dp (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .fsStrap(fsStrap),
    .hwN(hwN), .hwM(hwM), .progN(progN), .progM(progM),
    .recN(recN), .recM(recM), .overrideEn(overrideEn), .selReg(selReg),
    .strobes(strobes), .outN(outN), .outM(outM), .outRatio(outRatio)
  );
endmodule

// File: rtl/freqsel_wdog_ctrl_chk.sv
module freqsel_wdog_ctrl_chk #(
  parameter int N_W  = 8,
  parameter int M_W  = 7,
  parameter int WD_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            mWriteStb,
  input logic            recSel,
  input logic [N_W-1:0]  recN,
  input logic [M_W-1:0]  recM,
  input logic [WD_W-1:0] wdPeriod,
  input logic            wdTimeout,
  input logic            loadStb,
  input logic            rstOutN,
  input logic [N_W-1:0]  outN,
  input logic [M_W-1:0]  outM
);
  p_write_loads_r11: assert property (@(posedge clk) disable iff (!rstN)
    mWriteStb |=> loadStb);

  p_load_has_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> $past(mWriteStb || wdTimeout));

  p_write_resets_r9: assert property (@(posedge clk) disable iff (!rstN)
    mWriteStb |=> !rstOutN);

  p_timeout_resets_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout |=> !rstOutN);

  p_wd_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wdPeriod == '0) |-> !wdTimeout);

  p_recovery_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wdTimeout && recSel) |=> (outN == $past(recN) && outM == $past(recM)));
endmodule

bind freqsel_wdog_ctrl freqsel_wdog_ctrl_chk #(.N_W(N_W), .M_W(M_W), .WD_W(WD_W)) u_chk (
  .clk(clk), .rstN(rstN), .mWriteStb(mWriteStb), .recSel(recSel),
  .recN(recN), .recM(recM), .wdPeriod(wdPeriod), .wdTimeout(wdTimeout),
  .loadStb(loadStb), .rstOutN(rstOutN), .outN(outN), .outM(outM)
);

// File: tb/freqsel_wdog_ctrl_test.sv
module freqsel_wdog_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrGood = 1'b0;
  logic [4:0]  fsStrap = 5'h0B;
  logic [7:0]  hwN = 8'h40;
  logic [6:0]  hwM = 7'h11;
  logic        progEn = 1'b0;
  logic [7:0]  progN = '0;
  logic [6:0]  progM = '0;
  logic        mWriteStb = 1'b0;
  logic        overrideEn = 1'b0;
  logic [4:0]  selReg = '0;
  logic        recSel = 1'b0;
  logic [7:0]  recN = '0;
  logic [6:0]  recM = '0;
  logic [15:0] wdPeriod = '0;
  logic        wdKick = 1'b0;
  logic [7:0]  outN;
  logic [6:0]  outM;
  logic [4:0]  outRatio;
  logic        loadStb;
  logic        rstOutN;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freqsel_wdog_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic mWrite();
    mWriteStb = 1'b1;
    cyc(1);
    mWriteStb = 1'b0;
  endtask

  // arm watchdog with period p; returns at the negedge after the kick edge
  task automatic arm(input int p);
    wdPeriod = 16'(p);
    wdKick = 1'b1;
    cyc(1);
    wdKick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 outN", outN, 8'h40);
    chk("R1 outM", outM, 7'h11);
    chk("R1 ratio", outRatio, 0);
    chk("R1 loadStb", loadStb, 0);
    chk("R1 rstOutN", rstOutN, 1);
  endtask

  task automatic t_strap();
    pwrGood = 1'b1;
    cyc(1);
    chk("R2 capture", outRatio, 5'h0B);
    fsStrap = 5'h1F;
    cyc(3);
    chk("R2 hold", outRatio, 5'h0B);
    pwrGood = 1'b0;
    cyc(1);
    pwrGood = 1'b1;
    cyc(1);
    chk("R2 recapture", outRatio, 5'h1F);
  endtask

  task automatic t_ratio();
    overrideEn = 1'b1;
    selReg = 5'h07;
    cyc(1);
    chk("R3 override", outRatio, 5'h07);
    overrideEn = 1'b0;
    cyc(1);
    chk("R3 strap", outRatio, 5'h1F);
  endtask

  task automatic t_noWrite();
    progEn = 1'b1;
    progN = 8'h88;
    progM = 7'h22;
    cyc(3);
    chk("R5 no write", outN, 8'h40);
    hwN = 8'h41;
    cyc(1);
    chk("R5 hw live", outN, 8'h41);
  endtask

  task automatic t_progWrite();
    mWrite();
    chk("R4 progN", outN, 8'h88);
    chk("R4 progM", outM, 7'h22);
    chk("R11 load", loadStb, 1);
    chk("R9 low", rstOutN, 0);
    progN = 8'h99;
    progM = 7'h33;
    cyc(1);
    chk("R11 load one", loadStb, 0);
    chk("R5 prog hold", outN, 8'h88);
    cyc(14);
    chk("R9 still low", rstOutN, 0);
    cyc(1);
    chk("R9 released", rstOutN, 1);
  endtask

  task automatic t_retrigger();
    mWrite();
    cyc(5);
    mWrite();
    cyc(15);
    chk("R9 retrig low", rstOutN, 0);
    cyc(1);
    chk("R9 retrig high", rstOutN, 1);
  endtask

  task automatic t_hwWrite();
    progEn = 1'b0;
    mWrite();
    chk("R4 hw write", outN, 8'h41);
    progEn = 1'b1;
    cyc(20);
  endtask

  task automatic t_wdRecov();
    recSel = 1'b1;
    recN = 8'h55;
    recM = 7'h2A;
    arm(5);
    cyc(4);
    chk("R6 early", loadStb, 0);
    chk("R6 early rst", rstOutN, 1);
    cyc(1);
    wdPeriod = '0;
    chk("R7 recN", outN, 8'h55);
    chk("R7 recM", outM, 7'h2A);
    chk("R6 timeout rst", rstOutN, 0);
    recN = 8'h66;
    cyc(20);
    chk("R8 recovery held", outN, 8'h55);
    mWrite();
    chk("R8 left by write", outN, 8'h99);
    cyc(20);
  endtask

  task automatic t_wdKickOff();
    wdPeriod = 16'd4;
    wdKick = 1'b1;
    cyc(12);
    chk("R6 kick holds", rstOutN, 1);
    wdKick = 1'b0;
    wdPeriod = '0;
    cyc(12);
    chk("R6 disabled", rstOutN, 1);
    chk("R6 disabled src", outN, 8'h99);
  endtask

  task automatic t_wdHw();
    recSel = 1'b0;
    arm(3);
    cyc(3);
    wdPeriod = '0;
    chk("R7 hw on timeout", outN, 8'h41);
    chk("R11 load timeout", loadStb, 1);
    cyc(20);
  endtask

  task automatic t_collide();
    recSel = 1'b1;
    recN = 8'h77;
    recM = 7'h05;
    arm(3);
    cyc(2);
    mWriteStb = 1'b1;
    cyc(1);
    mWriteStb = 1'b0;
    wdPeriod = '0;
    chk("R10 timeout wins N", outN, 8'h77);
    chk("R10 timeout wins M", outM, 7'h05);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    cyc(2);
    t_reset();
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_strap();
    t_ratio();
    t_noWrite();
    t_progWrite();
    t_retrigger();
    t_hwWrite();
    t_wdRecov();
    t_wdKickOff();
    t_wdHw();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule